// File: doc/BRIEF.md
# SPI Register and FIFO Front End

This block sits between a simple 32-bit register bus and the serial engine of an SPI controller. Software configures the controller through a small set of word registers: an enable bit, clock settings, transmit and receive word setup, frame settings, interrupt enables and FIFO control. Those values are driven straight out to the serial engine, which does the shifting and is not part of this block.

Data moves through two 8-entry FIFOs, and both are reached through one data register. A bus write to that register queues a word for transmission. A bus read from it takes the oldest received word. The engine drains the transmit FIFO over a valid/ready stream: `tx_valid` is high while a word is queued, and the word in `tx_data` leaves the FIFO at a clock edge where `tx_ready` is also high. The receive stream has no back-pressure. A word presented with `rx_valid` while the receive FIFO holds 8 entries is dropped, and the drop is recorded as an overrun.

Three interrupt causes are latched: transmit level, receive level and receive overrun. Software clears each cause by writing 1 to its bit. A single interrupt line combines the latched causes that are enabled.

Top module: `sio_regbank`

## Requirements
- R1: After reset every register reads 0, except status, which reads 0x20 while `eng_busy` is low. After reset `irq`, `tx_valid` and `cfg_enable` are 0.
- R2: Configuration registers keep only their writable bits and drive them on the `cfg_*` outputs. Word offsets and masks: 0x04 clock (mask 0x70FF), 0x08 transmit word setup (mask 0x3FFF), 0x0C receive word setup (mask 0x00FF), 0x10 frame (mask 0xC000), 0x18 interrupt enable (mask 0x0019).
- R3: Bit 0 of offset 0x00 is the enable and drives `cfg_enable`. While it is 0, the transmit-level and receive-level causes are not set.
- R4: Offset 0x14 is read-only status. Bit 7 follows `eng_busy`, bit 5 is 1 while the transmit FIFO is not full, bit 0 is 1 while the receive FIFO is not empty, and all other bits are 0.
- R5: A write to offset 0x24 pushes into the transmit FIFO. The FIFO hands words to the engine in order over the `tx_valid`/`tx_ready` handshake. A write while 8 words are queued is dropped.
- R6: A read of offset 0x24 pops the receive FIFO, and the word appears on `bus_rdata` one cycle after the request. A read of an empty FIFO returns 0 and changes nothing.
- R7: A word offered on `rx_valid` while the receive FIFO is full is dropped, even if a bus read pops in the same cycle, and cause bit 0 (overrun) is latched.
- R8: At offset 0x20, writing 1 to bit 12 empties the transmit FIFO and writing 1 to bit 4 empties the receive FIFO, both at the edge of that write. Bits 12 and 4 always read 0. Bits 11:8 hold the transmit threshold and bits 3:0 hold the receive threshold.
- R9: Latched causes read at offset 0x1C. Bit 4 is set while the controller is enabled and the transmit level is at or below the transmit threshold. Bit 3 is set while the controller is enabled and the receive level is at or above the receive threshold.
- R10: Writing 1 to a bit of offset 0x1C clears that cause. If the cause's condition still holds at that edge, the cause stays set.
- R11: `irq` is 1 exactly when some latched cause has its matching enable bit (bit 4, 3 or 0 of offset 0x18) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address; bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| eng_busy | input | 1 | Serial engine busy |
| tx_valid | output | 1 | Transmit FIFO holds a word |
| tx_ready | input | 1 | Engine takes `tx_data` at this edge |
| tx_data | output | DW | Oldest transmit word |
| rx_valid | input | 1 | Engine offers a received word (no back-pressure) |
| rx_data | input | DW | Received word |
| cfg_enable | output | 1 | Controller enable |
| cfg_clock | output | 32 | Clock settings |
| cfg_txword | output | 32 | Transmit word setup |
| cfg_rxword | output | 32 | Receive word setup |
| cfg_frame | output | 32 | Frame settings |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes, FIFO pushes, pops and flushes take effect at the edge of the request. Read data is registered and appears one edge after the read request. A latched cause needs one more edge after the FIFO level or enable that sets it has changed, and `irq` follows the causes with no further delay. The bench drives each access at a falling edge and samples at the next falling edge. Before reading the causes or `irq` after a level change, it inserts one idle cycle, so every sample falls after the last register on that path has been updated.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [3:0] {
    RI_CTRL  = 4'd0,
    RI_CLK   = 4'd1,
    RI_TXWD  = 4'd2,
    RI_RXWD  = 4'd3,
    RI_FRAME = 4'd4,
    RI_STAT  = 4'd5,
    RI_IEN   = 4'd6,
    RI_ICLR  = 4'd7,
    RI_FCTL  = 4'd8,
    RI_DATA  = 4'd9
  } reg_idx_e;

  localparam logic [31:0] MSK_CTRL  = 32'h0000_0001;
  localparam logic [31:0] MSK_CLK   = 32'h0000_70FF;
  localparam logic [31:0] MSK_TXWD  = 32'h0000_3FFF;
  localparam logic [31:0] MSK_RXWD  = 32'h0000_00FF;
  localparam logic [31:0] MSK_FRAME = 32'h0000_C000;
  localparam logic [31:0] MSK_IEN   = 32'h0000_0019;
  localparam logic [31:0] MSK_FCTL  = 32'h0000_0F0F;

  localparam int ST_BUSY = 7;
  localparam int ST_TXNF = 5;
  localparam int ST_RXNE = 0;
  localparam int FC_TXFL = 12;
  localparam int FC_RXFL = 4;
  localparam int CA_TX   = 4;
  localparam int CA_RX   = 3;
  localparam int CA_OVR  = 0;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [LW-1:0] FULLV = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == FULLV);
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign dout    = mem[rp];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> level == $past(level));
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push && !flush |=> level == '0);
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/sio_cause.sv
module sio_cause #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] rx_lvl,
  input  logic [3:0]    tx_thr,
  input  logic [3:0]    rx_thr,
  input  logic          ovr_evt,
  input  logic [2:0]    clr,
  input  logic [2:0]    ien,
  output logic [2:0]    cause,
  output logic          irq
);
  // cause[2] = transmit level, cause[1] = receive level, cause[0] = overrun
  logic [2:0] set;

  always_comb begin
    set[2] = en && (8'(tx_lvl) <= 8'(tx_thr));
    set[1] = en && (8'(rx_lvl) >= 8'(rx_thr));
    set[0] = ovr_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause <= '0;
    else        cause <= (cause & ~clr) | set;
  end

  assign irq = |(cause & ien);

  // R7
  ovr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> cause[0]);
  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr[0] && !ovr_evt |=> !cause[0]);
  // R3
  level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cause[2:1] & ~$past(cause[2:1])) == 2'b00);
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          eng_busy,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          cfg_enable,
  output logic [31:0]   cfg_clock,
  output logic [31:0]   cfg_txword,
  output logic [31:0]   cfg_rxword,
  output logic [31:0]   cfg_frame,
  output logic          irq
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [3:0]    idx;
  logic          wr, rd, unused_addr;
  logic [31:0]   ctrl_q, clk_q, txwd_q, rxwd_q, frame_q, ien_q, fc_q;
  logic [31:0]   stat, causes32, rmux;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic [DW-1:0] rx_dout;
  logic          tx_flush, rx_flush, tx_push, rx_pop, ovr_evt;
  logic [2:0]    cause, clr;

  assign idx         = bus_addr[5:2];
  assign unused_addr = ^bus_addr[1:0];
  assign wr          = bus_req && bus_we;
  assign rd          = bus_req && !bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      clk_q   <= '0;
      txwd_q  <= '0;
      rxwd_q  <= '0;
      frame_q <= '0;
      ien_q   <= '0;
      fc_q    <= '0;
    end else if (wr) begin
      case (idx)
        RI_CTRL:  ctrl_q  <= bus_wdata & MSK_CTRL;
        RI_CLK:   clk_q   <= bus_wdata & MSK_CLK;
        RI_TXWD:  txwd_q  <= bus_wdata & MSK_TXWD;
        RI_RXWD:  rxwd_q  <= bus_wdata & MSK_RXWD;
        RI_FRAME: frame_q <= bus_wdata & MSK_FRAME;
        RI_IEN:   ien_q   <= bus_wdata & MSK_IEN;
        RI_FCTL:  fc_q    <= bus_wdata & MSK_FCTL;
        default:  ;
      endcase
    end
  end

  assign tx_flush = wr && (idx == RI_FCTL) && bus_wdata[FC_TXFL];
  assign rx_flush = wr && (idx == RI_FCTL) && bus_wdata[FC_RXFL];
  assign tx_push  = wr && (idx == RI_DATA);
  assign rx_pop   = rd && (idx == RI_DATA);
  assign ovr_evt  = rx_valid && rx_full;
  assign clr      = {bus_wdata[CA_TX], bus_wdata[CA_RX], bus_wdata[CA_OVR]}
                    & {3{wr && (idx == RI_ICLR)}};

  sio_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .flush(tx_flush), .push(tx_push), .din(bus_wdata[DW-1:0]),
    .pop(tx_ready), .dout(tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  sio_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .flush(rx_flush), .push(rx_valid), .din(rx_data),
    .pop(rx_pop), .dout(rx_dout), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  sio_cause #(.LW(LW)) u_cause (
    .clk, .rst_n, .en(ctrl_q[0]), .tx_lvl, .rx_lvl,
    .tx_thr(fc_q[11:8]), .rx_thr(fc_q[3:0]), .ovr_evt, .clr,
    .ien({ien_q[CA_TX], ien_q[CA_RX], ien_q[CA_OVR]}), .cause, .irq
  );

  always_comb begin
    stat          = '0;
    stat[ST_BUSY] = eng_busy;
    stat[ST_TXNF] = !tx_full;
    stat[ST_RXNE] = !rx_empty;
    causes32         = '0;
    causes32[CA_TX]  = cause[2];
    causes32[CA_RX]  = cause[1];
    causes32[CA_OVR] = cause[0];
    case (idx)
      RI_CTRL:  rmux = ctrl_q;
      RI_CLK:   rmux = clk_q;
      RI_TXWD:  rmux = txwd_q;
      RI_RXWD:  rmux = rxwd_q;
      RI_FRAME: rmux = frame_q;
      RI_STAT:  rmux = stat;
      RI_IEN:   rmux = ien_q;
      RI_ICLR:  rmux = causes32;
      RI_FCTL:  rmux = fc_q;
      RI_DATA:  rmux = rx_empty ? '0 : 32'(rx_dout);
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rmux;
  end

  assign tx_valid   = !tx_empty;
  assign cfg_enable = ctrl_q[0];
  assign cfg_clock  = clk_q;
  assign cfg_txword = txwd_q;
  assign cfg_rxword = rxwd_q;
  assign cfg_frame  = frame_q;

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && (idx == RI_DATA) && rx_empty |=> bus_rdata == '0);
  // R4
  stat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && (idx == RI_STAT) |=> bus_rdata[ST_BUSY] == $past(eng_busy));
endmodule

// File: tb/sim_sio_regbank.sv
module sim_sio_regbank;
  localparam int CLK_P = 10;
  localparam int NV    = 14;
  // {word index, write value, expected read-back}
  localparam logic [67:0] VEC [NV] = '{
    {4'd1, 32'hFFFF_FFFF, 32'h0000_70FF},
    {4'd1, 32'h1234_5678, 32'h0000_5078},
    {4'd2, 32'hFFFF_FFFF, 32'h0000_3FFF},
    {4'd2, 32'h0000_0808, 32'h0000_0808},
    {4'd3, 32'hFFFF_FFFF, 32'h0000_00FF},
    {4'd4, 32'hFFFF_FFFF, 32'h0000_C000},
    {4'd4, 32'h0000_4000, 32'h0000_4000},
    {4'd6, 32'hFFFF_FFFF, 32'h0000_0019},
    {4'd6, 32'h0000_0000, 32'h0000_0000},
    {4'd8, 32'hFFFF_FFFF, 32'h0000_0F0F},
    {4'd8, 32'h0000_1313, 32'h0000_0303},
    {4'd8, 32'h0000_0203, 32'h0000_0203},
    {4'd0, 32'hFFFF_FFFF, 32'h0000_0001},
    {4'd0, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 0, rst_n = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        eng_busy = 0, tx_valid, tx_ready = 0, rx_valid = 0;
  logic [31:0] tx_data, rx_data = '0;
  logic        cfg_enable, irq;
  logic [31:0] cfg_clock, cfg_txword, cfg_rxword, cfg_frame;
  int          n_chk = 0, n_err = 0;
  logic [31:0] v;

  always #(CLK_P / 2) clk = ~clk;

  sio_regbank u0 (
    .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .eng_busy, .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_data,
    .cfg_enable, .cfg_clock, .cfg_txword, .cfg_rxword, .cfg_frame, .irq
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = {i, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = {i, 2'b00};
    @(negedge clk);
    d = bus_rdata; bus_req = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rxpush(input logic [31:0] d);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic txpop();
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd5, v); chk("R1 status after reset", v, 32'h20);
    rd(4'd7, v); chk("R1 causes after reset", v, 32'h0);
    chk("R1 irq/tx_valid/cfg_enable", {29'd0, irq, tx_valid, cfg_enable}, 32'h0);
    // R4 busy bit
    eng_busy = 1;
    rd(4'd5, v); chk("R4 status busy", v, 32'hA0);
    eng_busy = 0;

    // R2 R3 R8 R11 register read-back table
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][67:64], VEC[k][63:32]);
      rd(VEC[k][67:64], v);
      chk($sformatf("R2 table entry %0d", k), v, VEC[k][31:0]);
    end
    chk("R2 cfg_clock", cfg_clock, 32'h5078);
    chk("R2 cfg_txword", cfg_txword, 32'h0808);
    chk("R2 cfg_rxword", cfg_rxword, 32'hFF);
    chk("R2 cfg_frame", cfg_frame, 32'h4000);
    wr(4'd7, 32'h19); idle();
    rd(4'd7, v); chk("R10 clear all causes", v, 32'h0);

    // R5 transmit FIFO fill, order and drop when full
    for (int k = 0; k < 9; k++) wr(4'd9, 32'hA0 + k);
    rd(4'd5, v); chk("R4 R5 status tx full", v, 32'h00);
    for (int k = 0; k < 8; k++) begin
      chk("R5 tx order", tx_data, 32'hA0 + k);
      txpop();
    end
    chk("R5 ninth word dropped", {31'd0, tx_valid}, 32'h0);
    rd(4'd5, v); chk("R4 status tx drained", v, 32'h20);

    // R6 receive FIFO read path
    rxpush(32'hB0); rxpush(32'hB1); rxpush(32'hB2);
    rd(4'd5, v); chk("R4 status rx not empty", v, 32'h21);
    for (int k = 0; k < 3; k++) begin
      rd(4'd9, v); chk("R6 rx order", v, 32'hB0 + k);
    end
    rd(4'd9, v); chk("R6 empty read returns 0", v, 32'h0);
    rxpush(32'hC0);
    rd(4'd9, v); chk("R6 FIFO intact after empty read", v, 32'hC0);

    // R7 overrun
    for (int k = 0; k < 9; k++) rxpush(32'hD0 + k);
    rd(4'd7, v); chk("R7 overrun latched", v, 32'h01);
    for (int k = 0; k < 8; k++) begin
      rd(4'd9, v); chk("R7 kept words", v, 32'hD0 + k);
    end
    rd(4'd9, v); chk("R7 overflow word dropped", v, 32'h0);
    wr(4'd7, 32'h01);
    rd(4'd7, v); chk("R10 overrun cleared", v, 32'h0);

    // R8 flushes
    rxpush(32'hE0); rxpush(32'hE1);
    wr(4'd8, 32'h0213);
    rd(4'd5, v); chk("R8 rx flush", v, 32'h20);
    rd(4'd8, v); chk("R8 flush bits read 0", v, 32'h0203);
    wr(4'd9, 32'h55);
    wr(4'd8, 32'h1203);
    chk("R8 tx flush", {31'd0, tx_valid}, 32'h0);

    // R9 R10 R11 causes and interrupt (tx thr 2, rx thr 3)
    wr(4'd6, 32'h08);
    wr(4'd0, 32'h01); idle();
    rd(4'd7, v); chk("R9 tx cause at low level", v, 32'h10);
    chk("R11 irq masked", {31'd0, irq}, 32'h0);
    rxpush(32'h1); rxpush(32'h2); rxpush(32'h3); idle();
    rd(4'd7, v); chk("R9 rx cause at threshold", v, 32'h18);
    chk("R11 irq rx enabled", {31'd0, irq}, 32'h1);
    wr(4'd7, 32'h08); idle();
    rd(4'd7, v); chk("R10 cause re-sets while condition holds", v, 32'h18);
    rd(4'd9, v); idle();
    wr(4'd7, 32'h08); idle();
    rd(4'd7, v); chk("R10 rx cause cleared below threshold", v, 32'h10);
    chk("R11 irq low after clear", {31'd0, irq}, 32'h0);
    wr(4'd9, 32'h1); wr(4'd9, 32'h2); wr(4'd9, 32'h3); idle();
    wr(4'd7, 32'h10); idle();
    rd(4'd7, v); chk("R9 tx cause not set above threshold", v, 32'h0);
    wr(4'd6, 32'h10);
    chk("R11 irq low with nothing latched", {31'd0, irq}, 32'h0);
    txpop(); idle();
    chk("R11 irq from tx cause", {31'd0, irq}, 32'h1);
    rd(4'd7, v); chk("R9 tx cause at threshold", v, 32'h10);

    // R3 level causes gated by enable
    wr(4'd0, 32'h0);
    wr(4'd7, 32'h19); idle();
    rd(4'd7, v); chk("R3 no level cause while disabled", v, 32'h0);
    chk("R3 cfg_enable low", {31'd0, cfg_enable}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule